// File: doc/BRIEF.md
# Event Counter Monitor

A performance-monitoring block that counts hardware events and clock cycles and is driven through a 32-bit register bus with separate read and write strobes. Each of `NUM_CNT` event counters advances on its own pulse input. When `HAS_CYC` is set, a cycle counter is present at a fixed physical index, 31. Software selects which counters run and which may raise the interrupt through set/clear register pairs. It can preload any counter and starts or stops all counting through one global control word.

Each counter has a sticky overflow flag, which sets when the counter wraps from all ones to zero. The interrupt output is the OR of the flags whose interrupt enable is set. Per-counter event-type and filter words are plain storage that software can write and read back. A typical use is to preload a counter to half of full scale, enable it and its interrupt, and service the interrupt when the count wraps.

The bus has no back-pressure. A write completes in the cycle its strobe is high, and read data is returned exactly one cycle after the read strobe.

Top module: `event_monitor`

## Requirements
- R1: After reset, all counters, the enable masks, the overflow flags and the control word are zero, and `irq` is low.
- R2: Offset 0xE00 reads the constant {bit 14 = HAS_CYC, bits 13:8 = CNT_W-1, bits 7:0 = NUM_CNT-1}. Offset 0xE08 reads `ID_VAL`.
- R3: `rdata` holds the value read in the cycle after `rd_en` and is zero in every other cycle. Unmapped offsets, and counter slots that are not implemented, read zero.
- R4: Event counter n advances by one on each clock edge at which all three are high: `evt_in[n]`, control bit 0 and count-enable bit n. Otherwise it holds its value.
- R5: The cycle counter sits at counter slot 31 (offset 31*stride) and uses bit 31 of every mask word. It advances on every edge while control bit 0 and count-enable bit 31 are both set.
- R6: The count-enable word is set through 0xC00 and cleared through 0xC20. The interrupt-enable word is set through 0xC40 and cleared through 0xC60. Only bits written as 1 change. Both offsets of a pair read the current mask, and unimplemented bits read 0.
- R7: Counter n is at offset n*4 when CNT_W<=32, and at n*8 otherwise, with the low word at +0 and the high word at +4. A write loads the counter and takes priority over an increment in the same cycle.
- R8: Control (0xE04) bit 0 is the stored global enable and reads back. Writing 1 to bit 1 zeroes all event counters, and writing 1 to bit 2 zeroes the cycle counter. Bits 1 and 2 read 0.
- R9: A wrap from all ones to zero sets the counter's overflow bit. The overflow word reads at both 0xC80 and 0xCC0. Writing 1s at 0xC80 clears bits and writing 1s at 0xCC0 sets them. A wrap in the same cycle as a clear leaves the bit set.
- R10: `irq` is high exactly while some overflow bit and the matching interrupt-enable bit are both set. It rises in the cycle after the wrapping edge.
- R11: Event-type words at 0x400+4n keep their low TYPE_W bits. The cycle filter at 0x47C and the event filters at 0xA00+4n keep FILT_W bits. All of them read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| evt_in | input | NUM_CNT | Per-counter event increment pulses |
| irq | output | 1 | Overflow interrupt |

## Verification
Register writes, counter increments and overflow flags all take effect at the clock edge where the strobe or pulse is sampled, and `irq` follows on that same edge. Read data appears one edge after `rd_en`.

The bench drives stimulus at falling edges and samples at the next falling edge. Expected counts therefore equal the number of rising edges at which enable and pulse were both high.

Counting windows are framed by the global-enable writes. The cycle count is one more than the idle cycles between those two writes. The interrupt is checked both on the cycle before the wrapping edge and on the cycle after it.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam logic [11:0] A_CNTEN_SET = 12'hC00;
  localparam logic [11:0] A_CNTEN_CLR = 12'hC20;
  localparam logic [11:0] A_INTEN_SET = 12'hC40;
  localparam logic [11:0] A_INTEN_CLR = 12'hC60;
  localparam logic [11:0] A_OVF_CLR   = 12'hC80;
  localparam logic [11:0] A_OVF_SET   = 12'hCC0;
  localparam logic [11:0] A_CFG       = 12'hE00;
  localparam logic [11:0] A_CTRL      = 12'hE04;
  localparam logic [11:0] A_IDENT     = 12'hE08;
  localparam int          CYC_SLOT    = 31;

  function automatic int stride_shift(int width);
    return (width > 32) ? 3 : 2;
  endfunction

  function automatic logic [31:0] word_of(logic [63:0] v, logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction
endpackage

// File: rtl/evmon_setclr.sv
module evmon_setclr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_wr,
  input  logic         clr_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] set_v, clr_v;

  always_comb begin
    set_v = (set_wr ? wdata : '0) | hw_set;
    clr_v = clr_wr ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= ((q & ~clr_v) | set_v) & MASK;
  end

  // R6: written ones appear in the mask
  a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((q & $past(wdata & MASK)) == $past(wdata & MASK)));
  // R6: cleared bits drop unless hardware sets them
  a_r6_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !set_wr && hw_set == '0) |=> ((q & $past(wdata)) == '0));
  // R6: writing zeros changes nothing
  a_r6_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_wr || clr_wr) && wdata == '0 && hw_set == '0) |=> $stable(q));
  // R9: hardware set wins over a clear
  a_r9_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((q & $past(hw_set & MASK)) == $past(hw_set & MASK)));
endmodule

// File: rtl/evmon_counter.sv
module evmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic         ld_lo,
  input  logic         ld_hi,
  input  logic [31:0]  wdata,
  output logic [W-1:0] value,
  output logic         wrap
);
  logic [63:0] ext;

  assign ext  = 64'(value);
  assign wrap = inc && !clr && !ld_lo && !ld_hi && (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (clr)   value <= '0;
    else if (ld_lo) value <= W'({ext[63:32], wdata});
    else if (ld_hi) value <= W'({wdata, ext[31:0]});
    else if (inc)   value <= value + 1'b1;
  end

  // R9: a wrap lands on zero
  a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (value == '0));
  // R4: idle counter holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc || clr || ld_lo || ld_hi) |=> $stable(value));
  // R8: reset request zeroes
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (value == '0));
endmodule

// File: rtl/event_monitor.sv
module event_monitor
  import evmon_pkg::*;
#(
  parameter int          NUM_CNT = 4,
  parameter int          CNT_W   = 32,
  parameter bit          HAS_CYC = 1'b1,
  parameter int          TYPE_W  = 10,
  parameter int          FILT_W  = 32,
  parameter logic [31:0] ID_VAL  = 32'h0000_5A31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [11:0]        addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NUM_CNT-1:0] evt_in,
  output logic               irq
);
  localparam int          SSH      = stride_shift(CNT_W);
  localparam bit          WIDE     = (CNT_W > 32);
  localparam logic [31:0] IMPL     = 32'((64'd1 << NUM_CNT) - 64'd1) |
                                     (HAS_CYC ? 32'h8000_0000 : 32'h0);
  localparam logic [31:0] CFG_WORD = {17'd0, HAS_CYC, 6'(CNT_W - 1), 8'(NUM_CNT - 1)};

  // decode
  logic       is_cnt, is_typ, is_flt, chi;
  logic [7:0] cidx;
  logic [4:0] ridx;
  logic       ctrl_en;
  logic       clr_evt, clr_cyc;

  assign is_cnt  = (addr[11:10] == 2'b00);
  assign is_typ  = (addr[11:7] == 5'b01000);
  assign is_flt  = (addr[11:7] == 5'b10100);
  assign cidx    = 8'(addr[9:0] >> SSH);
  assign chi     = WIDE && addr[2];
  assign ridx    = addr[6:2];
  assign clr_evt = wr_en && (addr == A_CTRL) && wdata[1];
  assign clr_cyc = wr_en && (addr == A_CTRL) && wdata[2];

  // masks
  logic [31:0] cnten_q, inten_q, ovf_q, ovf_hw;

  evmon_setclr #(.W(32), .MASK(IMPL)) u_cnten (
    .clk(clk), .rst_n(rst_n),
    .set_wr(wr_en && addr == A_CNTEN_SET), .clr_wr(wr_en && addr == A_CNTEN_CLR),
    .wdata(wdata), .hw_set(32'd0), .q(cnten_q));

  evmon_setclr #(.W(32), .MASK(IMPL)) u_inten (
    .clk(clk), .rst_n(rst_n),
    .set_wr(wr_en && addr == A_INTEN_SET), .clr_wr(wr_en && addr == A_INTEN_CLR),
    .wdata(wdata), .hw_set(32'd0), .q(inten_q));

  evmon_setclr #(.W(32), .MASK(IMPL)) u_ovf (
    .clk(clk), .rst_n(rst_n),
    .set_wr(wr_en && addr == A_OVF_SET), .clr_wr(wr_en && addr == A_OVF_CLR),
    .wdata(wdata), .hw_set(ovf_hw), .q(ovf_q));

  // global control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ctrl_en <= 1'b0;
    else if (wr_en && addr == A_CTRL) ctrl_en <= wdata[0];
  end

  // counters
  logic [CNT_W-1:0]   cval [NUM_CNT];
  logic [NUM_CNT-1:0] cwrap;
  logic [CNT_W-1:0]   cyc_val;
  logic               cyc_wrap;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_evt
    evmon_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc(ctrl_en && cnten_q[g] && evt_in[g]),
      .clr(clr_evt),
      .ld_lo(wr_en && is_cnt && cidx == 8'(g) && !chi),
      .ld_hi(wr_en && is_cnt && cidx == 8'(g) && chi),
      .wdata(wdata), .value(cval[g]), .wrap(cwrap[g]));
  end

  if (HAS_CYC) begin : g_cyc
    evmon_counter #(.W(CNT_W)) u_cyc (
      .clk(clk), .rst_n(rst_n),
      .inc(ctrl_en && cnten_q[CYC_SLOT]),
      .clr(clr_cyc),
      .ld_lo(wr_en && is_cnt && cidx == 8'(CYC_SLOT) && !chi),
      .ld_hi(wr_en && is_cnt && cidx == 8'(CYC_SLOT) && chi),
      .wdata(wdata), .value(cyc_val), .wrap(cyc_wrap));
  end else begin : g_nocyc
    assign cyc_val  = '0;
    assign cyc_wrap = 1'b0;
  end

  assign ovf_hw = 32'(cwrap) | {cyc_wrap, 31'd0};

  // per-counter descriptors
  logic [TYPE_W-1:0] typ_q [NUM_CNT];
  logic [FILT_W-1:0] flt_q [NUM_CNT];
  logic [FILT_W-1:0] cflt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CNT; i++) begin
        typ_q[i] <= '0;
        flt_q[i] <= '0;
      end
      cflt_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (is_typ && ridx == 5'(i)) typ_q[i] <= TYPE_W'(wdata);
        if (is_flt && ridx == 5'(i)) flt_q[i] <= FILT_W'(wdata);
      end
      if (is_typ && ridx == 5'(CYC_SLOT)) cflt_q <= FILT_W'(wdata);
    end
  end

  // read path
  logic [31:0] rmux;

  always_comb begin
    rmux = '0;
    if (is_cnt) begin
      for (int i = 0; i < NUM_CNT; i++)
        if (cidx == 8'(i)) rmux = word_of(64'(cval[i]), chi);
      if (HAS_CYC && cidx == 8'(CYC_SLOT)) rmux = word_of(64'(cyc_val), chi);
    end else if (is_typ) begin
      for (int i = 0; i < NUM_CNT; i++)
        if (ridx == 5'(i)) rmux = 32'(typ_q[i]);
      if (ridx == 5'(CYC_SLOT)) rmux = 32'(cflt_q);
    end else if (is_flt) begin
      for (int i = 0; i < NUM_CNT; i++)
        if (ridx == 5'(i)) rmux = 32'(flt_q[i]);
    end else begin
      case (addr)
        A_CNTEN_SET, A_CNTEN_CLR: rmux = cnten_q;
        A_INTEN_SET, A_INTEN_CLR: rmux = inten_q;
        A_OVF_SET, A_OVF_CLR:     rmux = ovf_q;
        A_CFG:                    rmux = CFG_WORD;
        A_CTRL:                   rmux = {31'd0, ctrl_en};
        A_IDENT:                  rmux = ID_VAL;
        default:                  rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rmux : 32'd0;
  end

  assign irq = |(ovf_q & inten_q);

  // R3: no read, no data
  a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == 32'd0));
  // R10: interrupt rises only after a wrap or a set/enable write
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((ovf_hw != 32'd0) ||
                         (wr_en && (addr == A_OVF_SET || addr == A_INTEN_SET))));
  // R8: without the global enable the cycle counter only changes by write or reset
  a_r8_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !wr_en) |=> $stable(cyc_val));
endmodule

// File: tb/event_monitor_test.sv
module event_monitor_test;
  localparam int TCK = 10;
  localparam int NC  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] evt_in = '0;
  logic          irq;

  int total = 0, bad = 0;
  bit done = 0;

  event_monitor #(.NUM_CNT(NC), .CNT_W(16), .HAS_CYC(1'b1), .TYPE_W(10),
                  .FILT_W(32), .ID_VAL(32'h0000_5A31)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .irq(irq));

  always #(TCK/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp_c [NC];
    logic [NC-1:0] en;
    for (int i = 0; i < NC; i++) exp_c[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    rchk("R1 cnten", 12'hC00, 32'd0);
    rchk("R1 ovf", 12'hC80, 32'd0);
    rchk("R1 ctrl", 12'hE04, 32'd0);
    rchk("R1 cnt0", 12'h000, 32'd0);

    // R2 / R3
    rchk("R2 cfg", 12'hE00, 32'h0000_4F03);
    rchk("R2 id", 12'hE08, 32'h0000_5A31);
    rchk("R3 unmapped", 12'hF00, 32'd0);
    rchk("R3 absent slot", 12'h014, 32'd0);
    check("R3 idle rdata", rdata, 32'd0);

    // R6 set/clear masks
    wr(12'hC00, 32'hFFFF_FFFF);
    rchk("R6 set read", 12'hC00, 32'h8000_000F);
    rchk("R6 clr read", 12'hC20, 32'h8000_000F);
    wr(12'hC20, 32'd0);
    rchk("R6 zero write", 12'hC00, 32'h8000_000F);
    wr(12'hC20, 32'h5);
    rchk("R6 clear bits", 12'hC20, 32'h8000_000A);

    // R5 cycle counter: 5 idle cycles between enable and disable -> 6 edges
    wr(12'hE04, 32'h1);
    repeat (5) @(negedge clk);
    wr(12'hE04, 32'h0);
    rchk("R5 cycle count", 12'h07C, 32'd6);
    rchk("R4 no pulses", 12'h004, 32'd0);

    // R4 sweep: counters 0,1,3 enabled, 2 disabled
    wr(12'hC20, 32'h8000_0000);
    wr(12'hC00, 32'h1);
    en = 4'b1011;
    wr(12'hE04, 32'h1);
    for (int i = 0; i < 24; i++) begin
      evt_in = 4'((i * 7 + 3) % 16);
      for (int n = 0; n < NC; n++) exp_c[n] += (evt_in[n] && en[n]) ? 1 : 0;
      @(negedge clk);
    end
    evt_in = '0;
    wr(12'hE04, 32'h0);
    for (int n = 0; n < NC; n++) rchk($sformatf("R4 sweep cnt%0d", n), 12'(n * 4), 32'(exp_c[n]));
    evt_in = 4'hF;
    repeat (4) @(negedge clk);
    evt_in = '0;
    rchk("R4 disabled global", 12'h000, 32'(exp_c[0]));

    // R8 control
    wr(12'hE04, 32'h1);
    rchk("R8 enable reads", 12'hE04, 32'h1);
    wr(12'hE04, 32'h3);
    rchk("R8 evt reset", 12'h000, 32'd0);
    rchk("R8 evt reset 3", 12'h00C, 32'd0);
    rchk("R8 cycle kept", 12'h07C, 32'd6);
    rchk("R8 pulse bits read 0", 12'hE04, 32'h1);
    wr(12'hE04, 32'h4);
    rchk("R8 cycle reset", 12'h07C, 32'd0);

    // R7 preload beats increment
    wr(12'hE04, 32'h1);
    evt_in = 4'b0001;
    wr(12'h000, 32'h1234);
    evt_in = '0;
    rchk("R7 preload", 12'h000, 32'h1234);
    wr(12'hE04, 32'h0);

    // R9 / R10 overflow and interrupt
    wr(12'hC40, 32'h2);
    wr(12'h004, 32'hFFFE);
    wr(12'hE04, 32'h1);
    evt_in = 4'b0010;
    @(negedge clk);
    check("R10 irq before wrap", {31'd0, irq}, 32'd0);
    @(negedge clk);
    evt_in = '0;
    check("R10 irq after wrap", {31'd0, irq}, 32'd1);
    wr(12'hE04, 32'h0);
    rchk("R9 ovf at clr", 12'hC80, 32'h2);
    rchk("R9 ovf at set", 12'hCC0, 32'h2);
    rchk("R9 wrapped to 0", 12'h004, 32'd0);
    wr(12'hC80, 32'h2);
    rchk("R9 ovf cleared", 12'hC80, 32'd0);
    check("R10 irq cleared", {31'd0, irq}, 32'd0);
    wr(12'hCC0, 32'h1);
    rchk("R9 ovf set write", 12'hC80, 32'h1);
    check("R10 masked", {31'd0, irq}, 32'd0);
    wr(12'hC40, 32'h1);
    check("R10 unmasked", {31'd0, irq}, 32'd1);
    rchk("R6 inten read", 12'hC60, 32'h3);
    wr(12'hC60, 32'h1);
    check("R10 remasked", {31'd0, irq}, 32'd0);

    // R11 descriptors
    wr(12'h408, 32'hFFFF_FFFF);
    rchk("R11 type width", 12'h408, 32'h0000_03FF);
    wr(12'h47C, 32'hDEAD_BEEF);
    rchk("R11 cycle filter", 12'h47C, 32'hDEAD_BEEF);
    wr(12'hA04, 32'h1234_5678);
    rchk("R11 event filter", 12'hA04, 32'h1234_5678);
    rchk("R11 other filter", 12'hA00, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule